// File: doc/BRIEF.md
# Write-Protect Sequence Guard

This block sits in the write path of a byte-wide nonvolatile memory, between the stage that captures each write cycle's address and data and the page buffer. It watches every captured write for a fixed command code written to two key addresses. It keeps a protect flag, and for each write it decides whether the byte may go on to the page buffer. A burst is a run of writes in which each write follows the one before it within a load window. When a burst ends, the block asks the write controller to start the program timer.

Three command writes arm protection. The same three writes also authorise the remaining writes of the burst they open. While protection is set, a burst that does not open with the code still starts the program timer, so the part looks busy, but none of its bytes are committed. A six-write code clears protection. Command writes are never committed. Any other value written to a key address is an ordinary write. The protect flag is a plain register that stands in for a nonvolatile bit.

Top module: `wp_guard`

## Requirements
- R1: After reset, protected_o is 0 and commit_en and timer_start are both 0.
- R2: While unprotected, a write that is not part of a command is committed: commit_en is high for one cycle in the cycle after wr_valid, and commit_addr and commit_data carry that write's address and data.
- R3: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 set protected_o in the cycle after the third write. None of the three is committed.
- R4: Ordinary writes that follow the R3 code in the same burst are committed, whether or not protection was already set.
- R5: While protected, a burst that does not open with the R3 code commits nothing, and it still produces a timer_start pulse.
- R6: Protection stays set across bursts until the six-write code runs: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. protected_o then clears and later writes are committed. None of the six is committed.
- R7: A write that does not match the next expected code step sends the detector back to idle, and that write is handled as an ordinary data write.
- R8: A write sampled at most LOAD_TIMEOUT cycles after the previous write stays in the same burst. A longer gap closes the burst and cancels any partial code and any authorisation.
- R9: timer_start is a one-cycle pulse. It is visible LOAD_TIMEOUT cycles after the cycle in which the last write of a burst is committed or dropped, and it comes for every burst, including a burst that holds only command writes.
- R10: A key address written with a value that is not the expected code byte is an ordinary location, and the write is committed when not protected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | ADDR_W | Address of the captured write |
| wr_data | input | DATA_W | Data of the captured write |
| commit_en | output | 1 | Write may enter the page buffer |
| commit_addr | output | ADDR_W | Address of the committed write |
| commit_data | output | DATA_W | Data of the committed write |
| timer_start | output | 1 | Burst closed; start the program timer |
| protected_o | output | 1 | Protect flag |

## Verification
The embedded assertions check the following on every cycle:
- the protect flag rises only after the detector reports a completed arm code, and falls only after a completed clear code;
- a command write never produces a commit;
- a commit always follows a write strobe;
- a closing burst always returns the detector to idle;
- the gap counter stays below the window.

Only the bench's scenarios can show the rest:
- which writes land, and with which address and data;
- that authorisation ends with its burst;
- the exact window boundary;
- the timer pulse for protected bursts that commit nothing.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_A1,
    SQ_A2,
    SQ_D3,
    SQ_D4,
    SQ_D5
  } seq_t;

  // Decoded comparisons of one write against the key addresses and codes
  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_lead;
    logic d_ack;
    logic d_lock;
    logic d_more;
    logic d_unlock;
  } hit_t;

  typedef struct packed {
    seq_t nxt;
    logic cmd;
    logic en;
    logic dis;
  } step_t;

  // One step of the code recogniser: next state and the events of this write
  function automatic step_t seq_step(input seq_t cur, input hit_t h);
    step_t r;
    r.nxt = SQ_IDLE;
    r.cmd = 1'b0;
    r.en  = 1'b0;
    r.dis = 1'b0;
    case (cur)
      SQ_IDLE: if (h.at_a && h.d_lead) begin r.nxt = SQ_A1; r.cmd = 1'b1; end
      SQ_A1:   if (h.at_b && h.d_ack)  begin r.nxt = SQ_A2; r.cmd = 1'b1; end
      SQ_A2: begin
        if (h.at_a && h.d_lock) begin
          r.cmd = 1'b1;
          r.en  = 1'b1;
        end else if (h.at_a && h.d_more) begin
          r.nxt = SQ_D3;
          r.cmd = 1'b1;
        end
      end
      SQ_D3:   if (h.at_a && h.d_lead) begin r.nxt = SQ_D4; r.cmd = 1'b1; end
      SQ_D4:   if (h.at_b && h.d_ack)  begin r.nxt = SQ_D5; r.cmd = 1'b1; end
      SQ_D5: begin
        if (h.at_a && h.d_unlock) begin
          r.cmd = 1'b1;
          r.dis = 1'b1;
        end
      end
      default: r.nxt = SQ_IDLE;
    endcase
    return r;
  endfunction

  // A data write passes when the part is open or the burst is authorised
  function automatic logic write_passes(input logic prot, input logic auth);
    return !prot || auth;
  endfunction

endpackage

// File: rtl/wp_burst_timer.sv
module wp_burst_timer #(
  parameter int LOAD_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  output logic burst_close,
  output logic timer_start
);
  localparam int CNT_W = $clog2(LOAD_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_TIMEOUT - 1);

  logic             open_q;
  logic [CNT_W-1:0] gap_q;

  // The window expires when the gap reaches its limit with no new write
  assign burst_close = open_q && (gap_q == LAST) && !wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      gap_q       <= '0;
      timer_start <= 1'b0;
    end else begin
      timer_start <= burst_close;
      if (wr_valid) begin
        open_q <= 1'b1;
        gap_q  <= '0;
      end else if (burst_close) begin
        open_q <= 1'b0;
        gap_q  <= '0;
      end else if (open_q) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R8
  gap_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= LAST);

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(15'h2AAA),
  parameter logic [DATA_W-1:0] CODE_LEAD   = DATA_W'(8'hAA),
  parameter logic [DATA_W-1:0] CODE_ACK    = DATA_W'(8'h55),
  parameter logic [DATA_W-1:0] CODE_LOCK   = DATA_W'(8'hA0),
  parameter logic [DATA_W-1:0] CODE_MORE   = DATA_W'(8'h80),
  parameter logic [DATA_W-1:0] CODE_UNLOCK = DATA_W'(8'h20)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              burst_close,
  output logic              is_cmd,
  output logic              ev_enable,
  output logic              ev_disable
);
  seq_t  state_q;
  hit_t  hits;
  step_t step;

  always_comb begin
    hits.at_a     = (wr_addr == KEY_ADDR_A);
    hits.at_b     = (wr_addr == KEY_ADDR_B);
    hits.d_lead   = (wr_data == CODE_LEAD);
    hits.d_ack    = (wr_data == CODE_ACK);
    hits.d_lock   = (wr_data == CODE_LOCK);
    hits.d_more   = (wr_data == CODE_MORE);
    hits.d_unlock = (wr_data == CODE_UNLOCK);
    step          = seq_step(state_q, hits);
  end

  assign is_cmd     = wr_valid && step.cmd;
  assign ev_enable  = wr_valid && step.en;
  assign ev_disable = wr_valid && step.dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else if (wr_valid) begin
      state_q <= step.nxt;
    end else if (burst_close) begin
      state_q <= SQ_IDLE;
    end
  end

  // R8
  seq_idle_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_close |=> (state_q == SQ_IDLE));

  // R3
  en_dis_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_enable && ev_disable));

endmodule

// File: rtl/wp_commit_gate.sv
module wp_commit_gate
  import wp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              is_cmd,
  input  logic              ev_enable,
  input  logic              ev_disable,
  input  logic              burst_close,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              protected_o
);
  logic prot_q;
  logic auth_q;

  assign protected_o = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q      <= 1'b0;
      auth_q      <= 1'b0;
      commit_en   <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      commit_en <= wr_valid && !is_cmd && write_passes(prot_q, auth_q);
      if (wr_valid) begin
        commit_addr <= wr_addr;
        commit_data <= wr_data;
      end
      if (ev_enable) begin
        prot_q <= 1'b1;
        auth_q <= 1'b1;
      end else if (ev_disable) begin
        prot_q <= 1'b0;
        auth_q <= 1'b0;
      end else if (burst_close) begin
        auth_q <= 1'b0;
      end
    end
  end

  // R3
  prot_rise_by_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_q) |-> $past(ev_enable));

  // R6
  prot_fall_by_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_q) |-> $past(ev_disable));

  // R3
  cmd_never_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_cmd) |=> !commit_en);

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              timer_start,
  output logic              protected_o
);
  logic burst_close;
  logic is_cmd;
  logic ev_enable;
  logic ev_disable;

  wp_burst_timer #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .burst_close (burst_close),
    .timer_start (timer_start)
  );

  wp_seq_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .burst_close (burst_close),
    .is_cmd      (is_cmd),
    .ev_enable   (ev_enable),
    .ev_disable  (ev_disable)
  );

  wp_commit_gate #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .is_cmd      (is_cmd),
    .ev_enable   (ev_enable),
    .ev_disable  (ev_disable),
    .burst_close (burst_close),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .protected_o (protected_o)
  );

  // R2
  commit_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> $past(wr_valid));

  // R9
  timer_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start |=> !timer_start);

endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        commit_en;
  logic [14:0] commit_addr;
  logic [7:0]  commit_data;
  logic        timer_start;
  logic        protected_o;

  always #5 clk = ~clk;

  wp_guard #(.ADDR_W(15), .DATA_W(8), .LOAD_TIMEOUT(T)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_data(commit_data), .timer_start(timer_start), .protected_o(protected_o)
  );

  typedef struct {
    logic [14:0] a;
    logic [7:0]  d;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int tmr_seen = 0;
  int exp_tmr = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Driver: one write strobe; expected commits go to the scoreboard
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp_c, input string tag);
    item_t it;
    if (exp_c) begin
      it.a = a; it.d = d; it.tag = tag;
      exp_q.push_back(it);
    end
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic arm_code(input string tag);
    wr(15'h5555, 8'hAA, 0, tag);
    wr(15'h2AAA, 8'h55, 0, tag);
    wr(15'h5555, 8'hA0, 0, tag);
  endtask

  task automatic clear_code(input string tag);
    wr(15'h5555, 8'hAA, 0, tag);
    wr(15'h2AAA, 8'h55, 0, tag);
    wr(15'h5555, 8'h80, 0, tag);
    wr(15'h5555, 8'hAA, 0, tag);
    wr(15'h2AAA, 8'h55, 0, tag);
    wr(15'h5555, 8'h20, 0, tag);
  endtask

  task automatic settle(input string tag);
    exp_tmr++;
    repeat (T + 2) @(negedge clk);
    chk({tag, " timer pulses"}, tmr_seen, exp_tmr);
    chk({tag, " pending commits"}, exp_q.size(), 0);
  endtask

  // Monitor: pops the scoreboard on each commit
  always @(negedge clk) begin
    if (rst_n) begin
      if (timer_start) tmr_seen++;
      if (commit_en) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R5 unexpected commit actual=%0h/%0h expected=none", commit_addr, commit_data);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (commit_addr != it.a || commit_data != it.d) begin
            failures++;
            $display("FAIL %s commit actual=%0h/%0h expected=%0h/%0h",
                     it.tag, commit_addr, commit_data, it.a, it.d);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 protected_o", protected_o, 0);
    chk("R1 commit_en", commit_en, 0);
    chk("R1 timer_start", timer_start, 0);

    // R2: open part, plain burst
    wr(15'h0010, 8'h01, 1, "R2");
    wr(15'h0011, 8'h02, 1, "R2");
    wr(15'h7FFF, 8'hFE, 1, "R2");
    settle("R2");

    // R10: key addresses with other data are ordinary
    wr(15'h5555, 8'h12, 1, "R10");
    wr(15'h2AAA, 8'hA0, 1, "R10");
    settle("R10");

    // R3 + R4: arm, then data in the same burst
    arm_code("R3");
    chk("R3 protected after code", protected_o, 1);
    wr(15'h0100, 8'h3C, 1, "R4");
    wr(15'h0101, 8'hC3, 1, "R4");
    settle("R4");

    // R5 + R9: protected, no code: dropped, exact timer pulse
    wr(15'h0102, 8'h77, 0, "R5");
    repeat (T - 1) @(negedge clk);
    chk("R9 no pulse before window", timer_start, 0);
    @(negedge clk);
    chk("R9 pulse at window", timer_start, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", timer_start, 0);
    exp_tmr++;
    chk("R5 timer pulses", tmr_seen, exp_tmr);
    chk("R6 still protected", protected_o, 1);

    // R4 + R8: authorisation ends with its burst
    arm_code("R4");
    wr(15'h0040, 8'h11, 1, "R4");
    wr(15'h007F, 8'h22, 1, "R4");
    wr(15'h0040, 8'h33, 1, "R4");
    settle("R4");
    wr(15'h0041, 8'h44, 0, "R8");
    settle("R8");

    // R7 while protected: broken code leaves nothing authorised
    wr(15'h5555, 8'hAA, 0, "R7");
    wr(15'h2AAA, 8'h66, 0, "R7");
    wr(15'h5555, 8'hA0, 0, "R7");
    wr(15'h0200, 8'h5A, 0, "R7");
    settle("R7");
    chk("R7 still protected", protected_o, 1);

    // R8: gap longer than window cancels partial code
    wr(15'h5555, 8'hAA, 0, "R8");
    wr(15'h2AAA, 8'h55, 0, "R8");
    exp_tmr++;
    repeat (T) @(negedge clk);
    wr(15'h5555, 8'hA0, 0, "R8");
    wr(15'h0300, 8'h81, 0, "R8");
    settle("R8");

    // R8: gap at window edge keeps code alive
    wr(15'h5555, 8'hAA, 0, "R8");
    repeat (T - 1) @(negedge clk);
    wr(15'h2AAA, 8'h55, 0, "R8");
    repeat (T - 1) @(negedge clk);
    wr(15'h5555, 8'hA0, 0, "R8");
    wr(15'h0301, 8'h82, 1, "R8");
    settle("R8");

    // R6: clear code, same-burst and later writes commit
    clear_code("R6");
    chk("R6 cleared", protected_o, 0);
    wr(15'h0400, 8'h99, 1, "R6");
    settle("R6");
    wr(15'h0401, 8'h98, 1, "R6");
    settle("R6");

    // R7 while open: the mismatching write is ordinary data
    wr(15'h5555, 8'hAA, 0, "R7");
    wr(15'h2AAA, 8'h66, 1, "R7");
    wr(15'h1234, 8'h5A, 1, "R7");
    settle("R7");
    chk("R7 open", protected_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule